// File: doc/BRIEF.md
# DMA Request Steering Controller

This block sits between a data-acquisition core and a host DMA engine that offers two request channels, A and B. It decides when each channel should ask for a transfer and routes each acknowledged transfer to the right place. An input transfer pops one word from the ADC result stream and returns it as read data. An output transfer loads the host's write data into one of two DAC holding registers.

A configuration write selects one of four steering modes and enables input and/or output. In the plain mode, channel A carries input and channel B carries output to DAC 0. In the interleaved mode, channel B alternates between DAC 0 and DAC 1. In the ping-pong mode, a single stream is requested on one channel at a time, and requesting flips to the other channel on every terminal count. In the split mode, channel A feeds DAC 0 and channel B feeds DAC 1 at the same time. Each channel has a terminal-count flag, which is set by the host's terminal-count marker and cleared by a write strobe.

Stream rules:
- The ADC side is valid/ready. `adc_valid` must stay high with stable data until `adc_ready` pops the word.
- Each DAC side is valid/ready. A held word stays valid until the DAC core takes it with `dac_ready`.
- The host acknowledges at most one channel per cycle. A transfer completes in a cycle where that channel's `dreq` and `dack` are both high and `dstb` is high.

Top module: `dma_steer`

## Requirements
- R1: After reset, `dreq`, `tc_flag`, `dac_valid` and `adc_ready` are all zero. The mode is plain, and input and output are both disabled.
- R2: Once a channel raises its request, the request stays high until a strobe completes a transfer on that channel or the mode is written.
- R3: After a completed transfer, the request is low in the following cycle. It can rise again one cycle after that, and only if a new need exists.
- R4: Mode 0 (plain): channel A requests while input is enabled and `adc_valid` is high. Channel B requests DAC 0 while output is enabled. An input transfer drives `adc_ready` high for exactly that cycle, with `host_rdata` equal to `adc_data`.
- R5: Mode 1 (interleaved): channel A behaves as in mode 0. Channel B's output transfers go to DAC 0, then DAC 1, then DAC 0, and so on, always starting at DAC 0.
- R6: Mode 2 (ping-pong): only the active channel requests. Channel A is active first. Each transfer carrying `dtc` moves activity to the other channel, without limit. The stream is input if input is enabled, otherwise output to DAC 0.
- R7: Mode 3 (split): channel A serves only DAC 0 and channel B serves only DAC 1. Both may request together, and the input enable has no effect.
- R8: An output request for a DAC is raised only while that DAC's holding register is empty (`dac_valid` low). `dac_data` holds the last written word; DAC 0 is bits [DW-1:0] and DAC 1 is bits [2*DW-1:DW].
- R9: A transfer with `dtc` high sets that channel's `tc_flag` bit (bit 0 = A, bit 1 = B). A `tc_clr` pulse clears it, but a set in the same cycle wins.
- R10: A configuration write withdraws pending requests and returns the interleave pointer to DAC 0 and the ping-pong selector to channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Steering mode 0..3 |
| cfg_in_en | input | 1 | Enable input transfers |
| cfg_out_en | input | 1 | Enable output transfers |
| adc_valid | input | 1 | ADC result word available |
| adc_ready | output | 1 | Pop the ADC word |
| adc_data | input | DW | ADC result word |
| dreq | output | 2 | DMA request per channel (bit 0 = A) |
| dack | input | 2 | DMA acknowledge per channel |
| dstb | input | 1 | Transfer data strobe |
| dtc | input | 1 | Terminal count marker, qualified by the strobe |
| host_wdata | input | DW | Host write data for DAC transfers |
| host_rdata | output | DW | Read data for input transfers |
| tc_clr | input | 2 | Terminal-count flag clear strobe per channel |
| tc_flag | output | 2 | Terminal-count flag per channel |
| dac_valid | output | 2 | DAC holding register full |
| dac_ready | input | 2 | DAC core takes the held word |
| dac_data | output | 2*DW | Held words, DAC 0 in the low half |

## Verification
The bench checks that a transfer is never followed by a duplicate request: a design that re-evaluates need in the same edge as the strobe would request a full DAC again. It checks the interleave order across a DAC that is still full, where a broken pointer would stall or overwrite DAC 1. It runs ping-pong through several terminal counts and a mid-sequence mode write, where a stuck selector would leave channel B requesting. A terminal count that lands together with a clear must leave the flag set; a clear-priority design would lose that event.

// File: rtl/dma_steer_pkg.sv
package dma_steer_pkg;
  localparam int NCH  = 2;
  localparam int NDAC = 2;

  typedef enum logic [1:0] {
    MODE_PLAIN    = 2'd0,
    MODE_ILV      = 2'd1,
    MODE_PINGPONG = 2'd2,
    MODE_SPLIT    = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ROLE_IDLE = 2'd0,
    ROLE_ADC  = 2'd1,
    ROLE_DAC0 = 2'd2,
    ROLE_DAC1 = 2'd3
  } chan_role_e;

  // Work out what a channel is for, given the mode and the sequencing state.
  function automatic chan_role_e role_of(input xfer_mode_e m, input logic ch,
                                         input logic in_en, input logic out_en,
                                         input logic pp_sel, input logic ilv_ptr);
    chan_role_e r;
    r = ROLE_IDLE;
    case (m)
      MODE_PLAIN: begin
        if (!ch && in_en) r = ROLE_ADC;
        if (ch && out_en) r = ROLE_DAC0;
      end
      MODE_ILV: begin
        if (!ch && in_en) r = ROLE_ADC;
        if (ch && out_en) r = ilv_ptr ? ROLE_DAC1 : ROLE_DAC0;
      end
      MODE_PINGPONG: begin
        if (ch == pp_sel) begin
          if (in_en)       r = ROLE_ADC;
          else if (out_en) r = ROLE_DAC0;
        end
      end
      default: begin
        if (out_en) r = ch ? ROLE_DAC1 : ROLE_DAC0;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dma_req_chan.sv
module dma_req_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic need,
  input  logic ack,
  input  logic stb,
  output logic req,
  output logic xfer
);
  logic req_q;

  assign xfer = req_q & ack & stb;
  assign req  = req_q;

  // Raise on need, hold until the strobe, never re-raise in the strobe edge.
  always_ff @(posedge clk) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (flush)  req_q <= 1'b0;
    else if (xfer)   req_q <= 1'b0;
    else if (need)   req_q <= 1'b1;
  end
endmodule

// File: rtl/dma_tc_flag.sv
module dma_tc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/dma_dac_hold.sv
module dma_dac_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= wdata;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_steer.sv
module dma_steer
  import dma_steer_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_mode,
  input  logic                 cfg_in_en,
  input  logic                 cfg_out_en,
  input  logic                 adc_valid,
  output logic                 adc_ready,
  input  logic [DW-1:0]        adc_data,
  output logic [NCH-1:0]       dreq,
  input  logic [NCH-1:0]       dack,
  input  logic                 dstb,
  input  logic                 dtc,
  input  logic [DW-1:0]        host_wdata,
  output logic [DW-1:0]        host_rdata,
  input  logic [NCH-1:0]       tc_clr,
  output logic [NCH-1:0]       tc_flag,
  output logic [NDAC-1:0]      dac_valid,
  input  logic [NDAC-1:0]      dac_ready,
  output logic [NDAC*DW-1:0]   dac_data
);
  xfer_mode_e mode_q;
  logic       in_en_q, out_en_q, pp_sel_q, ilv_ptr_q;

  chan_role_e          role [NCH];
  logic [NCH-1:0]      need, xfer, tc_hit;
  logic [NDAC-1:0]     dac_load;
  logic                adc_pop;

  // Configuration register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_PLAIN;
      in_en_q  <= 1'b0;
      out_en_q <= 1'b0;
    end else if (cfg_wr) begin
      mode_q   <= xfer_mode_e'(cfg_mode);
      in_en_q  <= cfg_in_en;
      out_en_q <= cfg_out_en;
    end
  end

  // Ping-pong selector: flips on a terminal count of the active channel
  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr)
      pp_sel_q <= 1'b0;
    else if (mode_q == MODE_PINGPONG && tc_hit[pp_sel_q])
      pp_sel_q <= ~pp_sel_q;
  end

  // Interleave pointer: flips on every output transfer of channel B
  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr)
      ilv_ptr_q <= 1'b0;
    else if (mode_q == MODE_ILV && xfer[1] && role[1] != ROLE_IDLE)
      ilv_ptr_q <= ~ilv_ptr_q;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign role[c] = role_of(mode_q, 1'(c), in_en_q, out_en_q, pp_sel_q, ilv_ptr_q);
    assign need[c] = (role[c] == ROLE_ADC)  ? adc_valid :
                     (role[c] == ROLE_DAC0) ? ~dac_valid[0] :
                     (role[c] == ROLE_DAC1) ? ~dac_valid[1] : 1'b0;
    assign tc_hit[c] = xfer[c] & dtc;

    dma_req_chan u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (cfg_wr),
      .need  (need[c]),
      .ack   (dack[c]),
      .stb   (dstb),
      .req   (dreq[c]),
      .xfer  (xfer[c])
    );

    dma_tc_flag u_tc (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (tc_hit[c]),
      .clr   (tc_clr[c]),
      .flag  (tc_flag[c])
    );
  end

  // Steer completed transfers
  always_comb begin
    dac_load = '0;
    adc_pop  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (xfer[c]) begin
        case (role[c])
          ROLE_ADC:  adc_pop     = 1'b1;
          ROLE_DAC0: dac_load[0] = 1'b1;
          ROLE_DAC1: dac_load[1] = 1'b1;
          default:   ;
        endcase
      end
    end
  end

  assign adc_ready  = adc_pop;
  assign host_rdata = adc_data;

  for (genvar k = 0; k < NDAC; k++) begin : g_dac
    dma_dac_hold #(.DW(DW)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (dac_load[k]),
      .wdata (host_wdata),
      .ready (dac_ready[k]),
      .valid (dac_valid[k]),
      .data  (dac_data[k*DW +: DW])
    );
  end
endmodule

// File: rtl/dma_steer_chk.sv
module dma_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [1:0] mode,
  input logic [1:0] dreq,
  input logic [1:0] dack,
  input logic       dstb,
  input logic       dtc,
  input logic [1:0] tc_clr,
  input logic [1:0] tc_flag,
  input logic       adc_valid,
  input logic       adc_ready,
  input logic [1:0] dac_valid,
  input logic [1:0] dac_load
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dreq[c] && !(dack[c] && dstb) && !cfg_wr |=> dreq[c]);
    a_r3_drop_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      dreq[c] && dack[c] && dstb |=> !dreq[c]);
    a_r9_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
      dreq[c] && dack[c] && dstb && dtc |=> tc_flag[c]);
    a_r9_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      tc_clr[c] && !(dreq[c] && dack[c] && dstb && dtc) |=> !tc_flag[c]);
    a_r8_no_load_full: assert property (@(posedge clk) disable iff (!rst_n)
      dac_load[c] |-> !dac_valid[c]);
  end

  a_r6_pp_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 |-> !(dreq[0] && dreq[1]));
  a_r4_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ready |-> adc_valid);
  a_r10_cfg_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> dreq == 2'b00);
endmodule

bind dma_steer dma_steer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .mode      (mode_q),
  .dreq      (dreq),
  .dack      (dack),
  .dstb      (dstb),
  .dtc       (dtc),
  .tc_clr    (tc_clr),
  .tc_flag   (tc_flag),
  .adc_valid (adc_valid),
  .adc_ready (adc_ready),
  .dac_valid (dac_valid),
  .dac_load  (dac_load)
);

// File: tb/dma_steer_tb_top.sv
module dma_steer_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_in_en = 1'b0, cfg_out_en = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic adc_valid = 1'b0, adc_ready;
  logic [DW-1:0] adc_data = '0, host_wdata = '0, host_rdata;
  logic [1:0] dreq, dack = 2'b00, tc_clr = 2'b00, tc_flag, dac_valid, dac_ready = 2'b00;
  logic dstb = 1'b0, dtc = 1'b0;
  logic [2*DW-1:0] dac_data;

  int n_chk = 0, n_bad = 0;
  logic seen_ready;
  logic [DW-1:0] seen_rdata;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_steer #(.DW(DW)) dut_i (.*);

  // Row: [6:5] mode, [4] in_en, [3] out_en, [1:0] expected dreq
  localparam logic [6:0] VEC [9] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, 2'b01},
    {2'd0, 1'b0, 1'b1, 1'b0, 2'b10},
    {2'd0, 1'b1, 1'b1, 1'b0, 2'b11},
    {2'd1, 1'b1, 1'b1, 1'b0, 2'b11},
    {2'd2, 1'b1, 1'b1, 1'b0, 2'b01},
    {2'd2, 1'b0, 1'b1, 1'b0, 2'b01},
    {2'd3, 1'b0, 1'b1, 1'b0, 2'b11},
    {2'd3, 1'b1, 1'b0, 1'b0, 2'b00},
    {2'd0, 1'b0, 1'b0, 1'b0, 2'b00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Write config; returns at the negedge after the request could first rise
  task automatic cfg(input logic [1:0] m, input logic i, input logic o);
    cfg_wr = 1'b1; cfg_mode = m; cfg_in_en = i; cfg_out_en = o;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic xfer(input int ch, input logic [DW-1:0] wd, input logic tc, input logic [1:0] clr);
    dack = 2'b00; dack[ch] = 1'b1; dstb = 1'b1; dtc = tc; host_wdata = wd; tc_clr = clr;
    #1;
    seen_ready = adc_ready;
    seen_rdata = host_rdata;
    @(negedge clk);
    dack = 2'b00; dstb = 1'b0; dtc = 1'b0; tc_clr = 2'b00;
  endtask

  task automatic drain(input logic [1:0] which);
    dac_ready = which;
    @(negedge clk);
    dac_ready = 2'b00;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 dreq", 32'(dreq), 0);
    chk("R1 tc_flag", 32'(tc_flag), 0);
    chk("R1 dac_valid", 32'(dac_valid), 0);
    chk("R1 adc_ready", 32'(adc_ready), 0);

    // Table walk: request pattern per mode with input pending, DACs empty
    adc_valid = 1'b1;
    adc_data  = 16'h1234;
    for (int r = 0; r < 9; r++) begin
      cfg(VEC[r][6:5], VEC[r][4], VEC[r][3]);
      chk($sformatf("R4 R5 R6 R7 table row %0d", r), 32'(dreq), 32'(VEC[r][1:0]));
    end

    // Plain mode transfers
    cfg(2'd0, 1'b1, 1'b1);
    cyc(3);
    chk("R2 requests held", 32'(dreq), 32'h3);
    xfer(0, '0, 1'b0, 2'b00);
    chk("R4 adc_ready on input xfer", 32'(seen_ready), 1);
    chk("R4 rdata", 32'(seen_rdata), 32'h1234);
    chk("R3 req low after strobe", 32'(dreq[0]), 0);
    chk("R4 adc_ready one cycle", 32'(adc_ready), 0);
    cyc(1);
    chk("R3 req re-raised on new need", 32'(dreq[0]), 1);
    xfer(1, 16'hA5A5, 1'b0, 2'b00);
    chk("R4 B loads DAC0", 32'(dac_valid), 32'h1);
    chk("R4 DAC0 data", 32'(dac_data[DW-1:0]), 32'hA5A5);
    cyc(3);
    chk("R8 no req while DAC0 full", 32'(dreq[1]), 0);
    drain(2'b01);
    chk("R8 DAC0 taken", 32'(dac_valid), 0);
    cyc(1);
    chk("R8 req after DAC0 empties", 32'(dreq[1]), 1);

    // Interleaved output
    adc_valid = 1'b0;
    cfg(2'd1, 1'b0, 1'b1);
    chk("R5 B requests", 32'(dreq), 32'h2);
    xfer(1, 16'h0001, 1'b0, 2'b00);
    cyc(1);
    chk("R5 second req for DAC1", 32'(dreq[1]), 1);
    xfer(1, 16'h0002, 1'b0, 2'b00);
    chk("R5 both DACs loaded", 32'(dac_valid), 32'h3);
    chk("R5 DAC0 first word", 32'(dac_data[DW-1:0]), 32'h0001);
    chk("R5 DAC1 second word", 32'(dac_data[2*DW-1:DW]), 32'h0002);
    cyc(2);
    chk("R8 suppressed, DAC0 full", 32'(dreq[1]), 0);
    drain(2'b11);
    cyc(1);
    chk("R5 pointer back at DAC0", 32'(dreq[1]), 1);
    xfer(1, 16'h0003, 1'b0, 2'b00);
    chk("R5 third word to DAC0", 32'(dac_valid), 32'h1);
    chk("R5 DAC0 data third", 32'(dac_data[DW-1:0]), 32'h0003);
    drain(2'b01);

    // Ping-pong input
    adc_valid = 1'b1;
    cfg(2'd2, 1'b1, 1'b0);
    chk("R6 starts on A", 32'(dreq), 32'h1);
    xfer(0, '0, 1'b0, 2'b00);
    cyc(1);
    chk("R6 stays on A without tc", 32'(dreq), 32'h1);
    chk("R9 no flag without tc", 32'(tc_flag), 0);
    xfer(0, '0, 1'b1, 2'b00);
    chk("R9 flag A set", 32'(tc_flag), 32'h1);
    cyc(1);
    chk("R6 switched to B", 32'(dreq), 32'h2);
    xfer(1, '0, 1'b1, 2'b00);
    chk("R9 flag B set", 32'(tc_flag), 32'h3);
    cyc(1);
    chk("R6 back to A", 32'(dreq), 32'h1);
    xfer(0, '0, 1'b1, 2'b00);
    cyc(1);
    chk("R6 again to B", 32'(dreq), 32'h2);
    cfg(2'd2, 1'b1, 1'b0);
    chk("R10 selector reset to A", 32'(dreq), 32'h1);

    // Flag clear and collision
    tc_clr = 2'b10;
    @(negedge clk);
    tc_clr = 2'b00;
    chk("R9 clear B", 32'(tc_flag), 32'h1);
    tc_clr = 2'b01;
    @(negedge clk);
    tc_clr = 2'b00;
    chk("R9 clear A", 32'(tc_flag), 32'h0);
    xfer(0, '0, 1'b1, 2'b01);
    chk("R9 set wins over clear", 32'(tc_flag), 32'h1);

    // Split mode, input enabled but ignored
    cfg(2'd3, 1'b1, 1'b1);
    chk("R7 both channels request", 32'(dreq), 32'h3);
    xfer(0, 16'h00AA, 1'b0, 2'b00);
    chk("R7 no ADC pop on A", 32'(seen_ready), 0);
    xfer(1, 16'h00BB, 1'b0, 2'b00);
    chk("R7 no ADC pop on B", 32'(seen_ready), 0);
    chk("R7 DAC0 from A", 32'(dac_data[DW-1:0]), 32'h00AA);
    chk("R7 DAC1 from B", 32'(dac_data[2*DW-1:DW]), 32'h00BB);
    chk("R7 both loaded", 32'(dac_valid), 32'h3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule